// File: doc/BRIEF.md
# Strobed handshake port controller

This block holds the handshake logic for two 8-bit ports running in strobed mode, called port A (index 0) and port B (index 1). Each port has an active-low strobe line from its peripheral, a buffer-full line and an interrupt-request line. A per-port direction bit selects the mode. In input mode, a falling strobe latches the peripheral's data and marks the buffer full, which tells the peripheral to wait. The host then takes the byte. In output mode, a host write puts a byte on the port pins and marks the buffer full. The peripheral acknowledges with a strobe, whose falling edge empties the buffer.

In either mode, the strobe's trailing (rising) edge raises the interrupt request, but only when that port's interrupt-enable bit is set. A host that does not use interrupts can poll a status byte instead. The status byte holds both ports' interrupt, buffer-full and enable bits, plus a timer terminal-count flag. Both strobes are asynchronous. Each one passes through a two-flop synchroniser before its edges are detected.

The input byte reaches the host as a valid/ready stream. `up_valid` is high while an input-mode buffer is full. A transfer happens on a cycle where `up_valid` and `up_ready` are both high, and the buffer empties after it. Output bytes come in through `wr_valid` with no ready: a write is always accepted and replaces the byte already there. A peripheral that strobes again before the host has read loses the older byte. A sticky overrun flag records this, for verification.

Top module: `hs_pair_ctrl`

## Requirements
- R1: After reset, buf_full, intr, overrun, up_valid, pin_out and status are all zero.
- R2: In input mode, a falling strobe latches pin_in into up_data and sets buf_full (and up_valid). Both are due on the third rising clock edge after the strobe goes low.
- R3: A rising strobe sets intr on the third rising clock edge after it, if and only if that port's inte bit is 1. With inte at 0, intr stays 0.
- R4: In input mode, a cycle with up_valid and up_ready both high clears buf_full and intr on the next clock edge.
- R5: In output mode, wr_valid loads wr_data onto pin_out, sets buf_full and clears intr, all on the next clock edge.
- R6: In output mode, a falling strobe clears buf_full on the third rising edge after it.
- R7: A falling strobe in input mode while buf_full is already 1 overwrites up_data with the new pin_in. It also sets overrun, which stays 1 until reset.
- R8: The status byte is: bit 0 intr A, bit 1 buf_full A, bit 2 inte A, bit 3 intr B, bit 4 buf_full B, bit 5 inte B, bit 6 timer_tc, bit 7 always 0.
- R9: wr_valid in input mode leaves pin_out and buf_full unchanged. In output mode, a strobe leaves up_data unchanged, up_valid stays 0 and up_ready has no effect on buf_full.
- R10: The two ports are independent: activity on one leaves the other port's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_out | input | 2 | Per port: 1 = output mode, 0 = input mode |
| inte | input | 2 | Per port interrupt enable |
| stb_n | input | 2 | Per port asynchronous active-low strobe |
| pin_in | input | 2x8 | Peripheral data toward each port |
| pin_out | output | 2x8 | Data each port drives to its peripheral |
| buf_full | output | 2 | Per port buffer-full line |
| intr | output | 2 | Per port interrupt request |
| up_valid | output | 2 | Input byte available to host |
| up_data | output | 2x8 | Latched input byte |
| up_ready | input | 2 | Host takes the input byte |
| wr_valid | input | 2 | Host writes an output byte (always accepted) |
| wr_data | input | 2x8 | Output byte from host |
| timer_tc | input | 1 | Timer terminal-count flag for the status byte |
| status | output | 8 | Packed status byte |
| overrun | output | 2 | Sticky lost-byte flag, for verification |

## Verification
Any result driven by a strobe edge goes through two synchroniser flops and one state flop, so it is due on the third rising edge after the strobe changes. The bench checks that the result is still absent after the second edge and present after the third. Host reads and writes act on the next edge. The bench drives every input and samples every output one nanosecond after a rising edge, so each check falls at a known edge count from its stimulus.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int NPORT = 2;
  localparam int STW   = 8;

  function automatic logic [STW-1:0] pack_status(
    input logic [NPORT-1:0] irq,
    input logic [NPORT-1:0] full,
    input logic [NPORT-1:0] ien,
    input logic             tc
  );
    logic [STW-1:0] s;
    s = '0;
    for (int p = 0; p < NPORT; p++) begin
      s[3*p]     = irq[p];
      s[3*p + 1] = full[p];
      s[3*p + 2] = ien[p];
    end
    s[3*NPORT] = tc;
    return s;
  endfunction
endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], async_n};
      last  <= chain[STAGES-1];
    end
  end

  assign fall = last & ~chain[STAGES-1];
  assign rise = ~last & chain[STAGES-1];
endmodule

// File: rtl/hs_port.sv
module hs_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_out,
  input  logic          inte,
  input  logic          fall,
  input  logic          rise,
  input  logic [DW-1:0] pin_in,
  input  logic          up_ready,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          buf_full,
  output logic          intr,
  output logic          overrun,
  output logic          up_valid,
  output logic [DW-1:0] up_data,
  output logic [DW-1:0] pin_out
);
  logic full_q, irq_q, ovr_q;
  logic [DW-1:0] in_q, out_q;
  logic take;

  assign up_valid = full_q & ~mode_out;
  assign take     = up_valid & up_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
    end else if (!mode_out) begin
      if (fall) begin
        in_q   <= pin_in;
        full_q <= 1'b1;
        if (full_q && !take) ovr_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
      if (rise && inte)  irq_q <= 1'b1;
      else if (take)     irq_q <= 1'b0;
    end else begin
      if (wr_valid) begin
        out_q  <= wr_data;
        full_q <= 1'b1;
      end else if (fall) begin
        full_q <= 1'b0;
      end
      if (rise && inte)  irq_q <= 1'b1;
      else if (wr_valid) irq_q <= 1'b0;
    end
  end

  assign buf_full = full_q;
  assign intr     = irq_q;
  assign overrun  = ovr_q;
  assign up_data  = in_q;
  assign pin_out  = out_q;
endmodule

// File: rtl/hs_pair_ctrl.sv
module hs_pair_ctrl
  import hs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          mode_out,
  input  logic [NPORT-1:0]          inte,
  input  logic [NPORT-1:0]          stb_n,
  input  logic [NPORT-1:0][DW-1:0]  pin_in,
  output logic [NPORT-1:0][DW-1:0]  pin_out,
  output logic [NPORT-1:0]          buf_full,
  output logic [NPORT-1:0]          intr,
  output logic [NPORT-1:0]          up_valid,
  output logic [NPORT-1:0][DW-1:0]  up_data,
  input  logic [NPORT-1:0]          up_ready,
  input  logic [NPORT-1:0]          wr_valid,
  input  logic [NPORT-1:0][DW-1:0]  wr_data,
  input  logic                      timer_tc,
  output logic [STW-1:0]            status,
  output logic [NPORT-1:0]          overrun
);
  logic [NPORT-1:0] fall, rise;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    hs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (stb_n[p]),
      .fall    (fall[p]),
      .rise    (rise[p])
    );

    hs_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_out (mode_out[p]),
      .inte     (inte[p]),
      .fall     (fall[p]),
      .rise     (rise[p]),
      .pin_in   (pin_in[p]),
      .up_ready (up_ready[p]),
      .wr_valid (wr_valid[p]),
      .wr_data  (wr_data[p]),
      .buf_full (buf_full[p]),
      .intr     (intr[p]),
      .overrun  (overrun[p]),
      .up_valid (up_valid[p]),
      .up_data  (up_data[p]),
      .pin_out  (pin_out[p])
    );
  end

  always_comb status = pack_status(intr, buf_full, inte & {NPORT{rst_n}}, timer_tc & rst_n);
endmodule

// File: rtl/hs_pair_ctrl_chk.sv
module hs_pair_ctrl_chk
  import hs_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NPORT-1:0]          mode_out,
  input logic [NPORT-1:0]          inte,
  input logic [NPORT-1:0]          stb_n,
  input logic [NPORT-1:0][DW-1:0]  pin_in,
  input logic [NPORT-1:0][DW-1:0]  pin_out,
  input logic [NPORT-1:0]          buf_full,
  input logic [NPORT-1:0]          intr,
  input logic [NPORT-1:0]          up_valid,
  input logic [NPORT-1:0][DW-1:0]  up_data,
  input logic [NPORT-1:0]          up_ready,
  input logic [NPORT-1:0]          wr_valid,
  input logic [NPORT-1:0][DW-1:0]  wr_data,
  input logic                      timer_tc,
  input logic [STW-1:0]            status,
  input logic [NPORT-1:0]          overrun
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R2: an input-mode buffer fills only after the strobe was seen low
    a_r2_fill_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(buf_full[p]) && !$past(mode_out[p])) |-> !$past(stb_n[p], 3));

    // R3: interrupt rises only when enabled and after the strobe was high
    a_r3_intr_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr[p]) |-> ($past(inte[p]) && $past(stb_n[p], 3)));

    // R5: an output-mode write lands on the pins and fills the buffer
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out[p] && wr_valid[p]) |=> (buf_full[p] && pin_out[p] == $past(wr_data[p])));

    // R7: overrun is sticky
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[p] |=> overrun[p]);

    // R9: pins move only on an output-mode write
    a_r9_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_out[p] && wr_valid[p]) |=> $stable(pin_out[p]));
  end
endmodule

bind hs_pair_ctrl hs_pair_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/hs_pair_ctrl_test.sv
module hs_pair_ctrl_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_out = '0, inte = '0, stb_n = '1, up_ready = '0, wr_valid = '0;
  logic [1:0][DW-1:0] pin_in = '0, wr_data = '0;
  logic timer_tc = 1'b0;
  logic [1:0][DW-1:0] pin_out, up_data;
  logic [1:0] buf_full, intr, up_valid, overrun;
  logic [7:0] status;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  hs_pair_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_out(mode_out), .inte(inte), .stb_n(stb_n),
    .pin_in(pin_in), .pin_out(pin_out), .buf_full(buf_full), .intr(intr),
    .up_valid(up_valid), .up_data(up_data), .up_ready(up_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .timer_tc(timer_tc),
    .status(status), .overrun(overrun)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input logic [1:0] i, input logic [1:0] f,
                                            input logic [1:0] e, input logic t);
    return {1'b0, t, e[1], f[1], i[1], e[0], f[0], i[0]};
  endfunction

  task automatic t_reset();
    chk("R1 buf_full", 32'(buf_full), 0);
    chk("R1 intr", 32'(intr), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 up_valid", 32'(up_valid), 0);
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 status", 32'(status), 0);
  endtask

  task automatic t_input_a();
    inte[0] = 1'b1; pin_in[0] = 8'h5A;
    stb_n[0] = 1'b0;
    step(2);
    chk("R2 not yet full", 32'(buf_full[0]), 0);
    step(1);
    chk("R2 full", 32'(buf_full[0]), 1);
    chk("R2 up_valid", 32'(up_valid[0]), 1);
    chk("R2 up_data", 32'(up_data[0]), 32'h5A);
    chk("R8 status full", 32'(status), 32'(exp_status(2'b00, 2'b01, 2'b01, 1'b0)));
    stb_n[0] = 1'b1;
    step(2);
    chk("R3 not yet intr", 32'(intr[0]), 0);
    step(1);
    chk("R3 intr", 32'(intr[0]), 1);
    chk("R8 status intr", 32'(status), 32'h07);
    chk("R10 port B quiet", 32'({buf_full[1], intr[1]}), 0);
    up_ready[0] = 1'b1;
    step(1);
    up_ready[0] = 1'b0;
    chk("R4 bf clear", 32'(buf_full[0]), 0);
    chk("R4 intr clear", 32'(intr[0]), 0);
    chk("R4 status", 32'(status), 32'h04);
  endtask

  task automatic t_noint_b();
    inte[1] = 1'b0; pin_in[1] = 8'hA7;
    stb_n[1] = 1'b0; step(3);
    chk("R2 B full", 32'(buf_full[1]), 1);
    chk("R2 B data", 32'(up_data[1]), 32'hA7);
    stb_n[1] = 1'b1; step(4);
    chk("R3 B no intr when disabled", 32'(intr[1]), 0);
    chk("R8 status B", 32'(status), 32'(exp_status(2'b00, 2'b10, 2'b01, 1'b0)));
    up_ready[1] = 1'b1; step(1); up_ready[1] = 1'b0;
    chk("R4 B clear", 32'(buf_full[1]), 0);
  endtask

  task automatic t_overrun_a();
    pin_in[0] = 8'h11;
    stb_n[0] = 1'b0; step(3); stb_n[0] = 1'b1; step(3);
    chk("R7 first byte", 32'(up_data[0]), 32'h11);
    chk("R7 no overrun yet", 32'(overrun[0]), 0);
    pin_in[0] = 8'h22;
    stb_n[0] = 1'b0; step(3);
    chk("R7 overwritten", 32'(up_data[0]), 32'h22);
    chk("R7 overrun set", 32'(overrun), 32'h1);
    stb_n[0] = 1'b1; step(3);
    up_ready[0] = 1'b1; step(1); up_ready[0] = 1'b0;
    step(2);
    chk("R4 bf clear after overrun", 32'(buf_full[0]), 0);
    chk("R7 overrun sticky", 32'(overrun[0]), 1);
  endtask

  task automatic t_ignore_a();
    wr_data[0] = 8'hFF; wr_valid[0] = 1'b1; step(1); wr_valid[0] = 1'b0;
    step(1);
    chk("R9 pin_out held", 32'(pin_out[0]), 0);
    chk("R9 bf held", 32'(buf_full[0]), 0);
  endtask

  task automatic t_output_b();
    logic [DW-1:0] held;
    mode_out[1] = 1'b1; inte[1] = 1'b1; step(1);
    wr_data[1] = 8'hC3; wr_valid[1] = 1'b1; step(1); wr_valid[1] = 1'b0;
    chk("R5 pin_out", 32'(pin_out[1]), 32'hC3);
    chk("R5 bf set", 32'(buf_full[1]), 1);
    chk("R9 up_valid low in output", 32'(up_valid[1]), 0);
    up_ready[1] = 1'b1; step(1); up_ready[1] = 1'b0;
    chk("R9 up_ready ignored", 32'(buf_full[1]), 1);
    held = up_data[1];
    pin_in[1] = 8'h99;
    stb_n[1] = 1'b0; step(2);
    chk("R6 bf still set", 32'(buf_full[1]), 1);
    step(1);
    chk("R6 bf cleared", 32'(buf_full[1]), 0);
    chk("R9 up_data held", 32'(up_data[1]), 32'(held));
    stb_n[1] = 1'b1; step(3);
    chk("R3 B intr", 32'(intr[1]), 1);
    chk("R8 status out", 32'(status), 32'(exp_status(2'b10, 2'b00, 2'b11, 1'b0)));
    wr_data[1] = 8'h3C; wr_valid[1] = 1'b1; step(1); wr_valid[1] = 1'b0;
    chk("R5 intr cleared", 32'(intr[1]), 0);
    chk("R5 second byte", 32'(pin_out[1]), 32'h3C);
    chk("R10 port A pins", 32'(pin_out[0]), 0);
  endtask

  task automatic t_status_tc();
    timer_tc = 1'b1; #1;
    chk("R8 tc bit", 32'(status), 32'(exp_status(2'b00, 2'b10, 2'b11, 1'b1)));
    timer_tc = 1'b0;
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_input_a();
    t_noint_b();
    t_overrun_a();
    t_ignore_a();
    t_output_b();
    t_status_tc();
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule